// File: doc/BRIEF.md
# Chip-Select Bus Cycle Timing Sequencer

This block runs one external memory access at a time, read or write, into one of four chip-select spaces. Once a request is accepted it puts out the address and the direction level, waits an address-to-select delay, pulls the space's active-low select, opens the read or write strobe for a fixed width, and then holds the select for a configurable time before it releases it. It ends each access with a one-tick done pulse. For reads it returns the data word it captured from the bus.

The sequencer runs on a clock at twice the system rate. One tick is one period of `clk`, and one system period is two ticks, so half-period steps are counted as whole ticks. The address delay, the write setup and hold, and the read hold are taken from configuration inputs. Read adjustment is enabled for each space separately. Write adjustment applies only to the single space chosen by a selector. A set recovery bit for a space forces that space to basic timing. The configuration is sampled when a request is accepted.

Top module: `cs_bus_timer`

## Requirements
- R1: While `rst_n` is low and after its release, all `bus_cs_n_o` lines, `bus_rd_n_o` and `bus_wr_n_o` are high, and `done_o` and `busy_o` are low.
- R2: In an adjusted access, `cfg_addr_dly_i` codes 0, 1 and 2 give 0, 2 and 4 ticks between the first tick of valid address and direction (the tick after acceptance) and the first tick of select low. Code 3 acts as code 2.
- R3: A write is adjusted when its space equals `cfg_wr_sel_i`. It then has 2*`cfg_wr_sh_i`+1 ticks from select low to write strobe low, and the same count from write strobe high to select high.
- R4: A write to any space other than `cfg_wr_sel_i` has zero address delay, zero setup and zero hold.
- R5: A read to space s is adjusted only when bit s of `cfg_rd_en_i` is 1. It then has 2*`cfg_rd_hold_i[2s+1:2s]` ticks from read strobe high to select high, zero setup, and the R2 address delay. An unadjusted read has zero address delay and zero hold.
- R6: When bit s of `cfg_recov_i` is 1, every access to space s uses zero address delay, zero setup and zero hold, whatever the other fields hold.
- R7: The strobe matching the direction (`bus_rd_n_o` for a read, `bus_wr_n_o` for a write) is low for exactly 4 ticks, and only while a select is low. The other strobe stays high. `bus_rnw_o` is 1 for a read and 0 for a write, and `bus_wdata_o` carries the request's write data.
- R8: For a read, `rdata_o` holds the value `bus_rdata_i` had during the last tick of the read strobe, from the done tick until the next read.
- R9: `start_i` is accepted only while `busy_o` is low. A start during an access has no effect on the address, the space, the timing or the number of done pulses.
- R10: Only the requested space's select goes low. `done_o` is high for exactly one tick, which is the first tick the select is high again, and `busy_o` is low in the tick after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the system rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request an access (taken when idle) |
| rnw_i | input | 1 | 1 = read, 0 = write |
| space_i | input | 2 | Target space index |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| cfg_addr_dly_i | input | 2 | Address-to-select delay code |
| cfg_wr_sh_i | input | 2 | Write setup/hold code |
| cfg_wr_sel_i | input | 2 | Space that receives adjusted write timing |
| cfg_rd_hold_i | input | 2*NSPACE | Read hold code, two bits per space |
| cfg_rd_en_i | input | NSPACE | Read adjustment enable per space |
| cfg_recov_i | input | NSPACE | Recovery enable per space (forces basic timing) |
| bus_rdata_i | input | DATA_W | Data returned by the memory |
| bus_addr_o | output | ADDR_W | Latched access address |
| bus_cs_n_o | output | NSPACE | Active-low selects |
| bus_rd_n_o | output | 1 | Active-low read strobe |
| bus_wr_n_o | output | 1 | Active-low write strobe |
| bus_rnw_o | output | 1 | Direction level |
| bus_wdata_o | output | DATA_W | Latched write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-tick completion pulse |
| rdata_o | output | DATA_W | Captured read data |

## Verification
A wrong phase or a wrong counter load shows on the very next access. The select or the strobe edges land on the wrong tick, so the address delay, setup, strobe width or hold measured at the pins is off by at least one tick. A corrupted latched space or direction shows as the wrong select line or the wrong strobe going low, and that is seen within the same access. A wrong capture point shows at the done tick, because the bench changes the read data on every tick, so any shift in the capture tick returns a different word.

// File: rtl/cs_bus_timer_pkg.sv
package cs_bus_timer_pkg;

   localparam int DUR_W = 4;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_ADDR   = 3'd1,
      PH_SETUP  = 3'd2,
      PH_STROBE = 3'd3,
      PH_HOLD   = 3'd4,
      PH_DONE   = 3'd5
   } phase_e;

   typedef struct packed {
      logic [DUR_W-1:0] addr_t;
      logic [DUR_W-1:0] setup_t;
      logic [DUR_W-1:0] hold_t;
   } dur_t;

endpackage

// File: rtl/cs_bus_cfg_resolve.sv
module cs_bus_cfg_resolve
   import cs_bus_timer_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic [SEL_W-1:0]          space_i,
   input  logic                      rnw_i,
   input  logic [1:0]                addr_dly_i,
   input  logic [1:0]                wr_sh_i,
   input  logic [SEL_W-1:0]          wr_sel_i,
   input  logic [2*(1<<SEL_W)-1:0]   rd_hold_i,
   input  logic [(1<<SEL_W)-1:0]     rd_en_i,
   input  logic [(1<<SEL_W)-1:0]     recov_i,
   output dur_t                      dur_o
);
   localparam int NSPACE = 1 << SEL_W;

   logic [1:0]       rh_arr [NSPACE];
   logic             adjust;
   logic [DUR_W-1:0] addr_ticks;

   for (genvar g = 0; g < NSPACE; g++) begin : g_rh
      assign rh_arr[g] = rd_hold_i[2*g +: 2];
   end

   assign adjust = !recov_i[space_i] &&
                   (rnw_i ? rd_en_i[space_i] : (space_i == wr_sel_i));

   always_comb begin
      unique case (addr_dly_i)
         2'd0:    addr_ticks = DUR_W'(0);
         2'd1:    addr_ticks = DUR_W'(2);
         default: addr_ticks = DUR_W'(4);
      endcase
   end

   always_comb begin
      dur_o = '0;
      if (adjust) begin
         dur_o.addr_t = addr_ticks;
         if (rnw_i) begin
            dur_o.hold_t = DUR_W'({rh_arr[space_i], 1'b0});
         end else begin
            dur_o.setup_t = DUR_W'({wr_sh_i, 1'b1});
            dur_o.hold_t  = DUR_W'({wr_sh_i, 1'b1});
         end
      end
   end

endmodule

// File: rtl/cs_bus_phase_seq.sv
module cs_bus_phase_seq
   import cs_bus_timer_pkg::*;
#(
   parameter int STROBE_TICKS = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start_i,
   input  dur_t   dur_i,
   output phase_e phase_o,
   output logic   last_strobe_o
);
   phase_e           phase_q, phase_d;
   logic [DUR_W-1:0] cnt_q, cnt_d;
   dur_t             dur_q, dur_d;

   initial begin : chk_params
      assert (STROBE_TICKS >= 1 && STROBE_TICKS < (1 << DUR_W))
         else $error("STROBE_TICKS out of range");
   end

   function automatic logic [DUR_W-1:0] ph_len(phase_e p, dur_t d);
      case (p)
         PH_ADDR:   return d.addr_t;
         PH_SETUP:  return d.setup_t;
         PH_STROBE: return DUR_W'(STROBE_TICKS);
         PH_HOLD:   return d.hold_t;
         default:   return DUR_W'(1);
      endcase
   endfunction

   function automatic phase_e first_live(phase_e p, dur_t d);
      phase_e q = p;
      for (int i = 0; i < 3; i++) begin
         if (ph_len(q, d) == '0) q = phase_e'(q + 3'd1);
      end
      return q;
   endfunction

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      dur_d   = dur_q;
      case (phase_q)
         PH_IDLE: begin
            if (start_i) begin
               dur_d   = dur_i;
               phase_d = first_live(PH_ADDR, dur_i);
               cnt_d   = ph_len(phase_d, dur_i) - DUR_W'(1);
            end
         end
         PH_DONE: phase_d = PH_IDLE;
         default: begin
            if (cnt_q == '0) begin
               phase_d = first_live(phase_e'(phase_q + 3'd1), dur_q);
               cnt_d   = ph_len(phase_d, dur_q) - DUR_W'(1);
            end else begin
               cnt_d = cnt_q - DUR_W'(1);
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         dur_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         dur_q   <= dur_d;
      end
   end

   assign phase_o       = phase_q;
   assign last_strobe_o = (phase_q == PH_STROBE) && (cnt_q == '0);

endmodule

// File: rtl/cs_bus_select_dec.sv
module cs_bus_select_dec #(
   parameter int SEL_W = 2
) (
   input  logic                  active_i,
   input  logic [SEL_W-1:0]      space_i,
   output logic [(1<<SEL_W)-1:0] cs_n_o
);
   localparam int NSPACE = 1 << SEL_W;

   for (genvar g = 0; g < NSPACE; g++) begin : g_cs
      assign cs_n_o[g] = !(active_i && (space_i == SEL_W'(g)));
   end

endmodule

// File: rtl/cs_bus_timer.sv
module cs_bus_timer
   import cs_bus_timer_pkg::*;
#(
   parameter int ADDR_W       = 24,
   parameter int DATA_W       = 16,
   parameter int SEL_W        = 2,
   parameter int STROBE_TICKS = 4,
   localparam int NSPACE      = 1 << SEL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                rnw_i,
   input  logic [SEL_W-1:0]    space_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   input  logic [1:0]          cfg_addr_dly_i,
   input  logic [1:0]          cfg_wr_sh_i,
   input  logic [SEL_W-1:0]    cfg_wr_sel_i,
   input  logic [2*NSPACE-1:0] cfg_rd_hold_i,
   input  logic [NSPACE-1:0]   cfg_rd_en_i,
   input  logic [NSPACE-1:0]   cfg_recov_i,
   input  logic [DATA_W-1:0]   bus_rdata_i,
   output logic [ADDR_W-1:0]   bus_addr_o,
   output logic [NSPACE-1:0]   bus_cs_n_o,
   output logic                bus_rd_n_o,
   output logic                bus_wr_n_o,
   output logic                bus_rnw_o,
   output logic [DATA_W-1:0]   bus_wdata_o,
   output logic                busy_o,
   output logic                done_o,
   output logic [DATA_W-1:0]   rdata_o
);
   initial begin : chk_params
      assert (ADDR_W > 0 && DATA_W > 0 && SEL_W > 0)
         else $error("cs_bus_timer: widths must be positive");
   end

   dur_t              dur;
   phase_e            phase;
   logic              last_strobe;
   logic              accept;
   logic              sel_active;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic [SEL_W-1:0]  space_q;
   logic              rnw_q;

   assign busy_o = (phase != PH_IDLE);
   assign accept = start_i && !busy_o;

   cs_bus_cfg_resolve #(.SEL_W(SEL_W)) resolve_i (
      .space_i    (space_i),
      .rnw_i      (rnw_i),
      .addr_dly_i (cfg_addr_dly_i),
      .wr_sh_i    (cfg_wr_sh_i),
      .wr_sel_i   (cfg_wr_sel_i),
      .rd_hold_i  (cfg_rd_hold_i),
      .rd_en_i    (cfg_rd_en_i),
      .recov_i    (cfg_recov_i),
      .dur_o      (dur)
   );

   cs_bus_phase_seq #(.STROBE_TICKS(STROBE_TICKS)) seq_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (accept),
      .dur_i         (dur),
      .phase_o       (phase),
      .last_strobe_o (last_strobe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         space_q <= '0;
         rnw_q   <= 1'b1;
         rdata_q <= '0;
      end else begin
         if (accept) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            space_q <= space_i;
            rnw_q   <= rnw_i;
         end
         if (last_strobe && rnw_q) rdata_q <= bus_rdata_i;
      end
   end

   assign sel_active = (phase == PH_SETUP) || (phase == PH_STROBE) ||
                       (phase == PH_HOLD);

   cs_bus_select_dec #(.SEL_W(SEL_W)) dec_i (
      .active_i (sel_active),
      .space_i  (space_q),
      .cs_n_o   (bus_cs_n_o)
   );

   assign bus_rd_n_o  = !((phase == PH_STROBE) && rnw_q);
   assign bus_wr_n_o  = !((phase == PH_STROBE) && !rnw_q);
   assign bus_addr_o  = addr_q;
   assign bus_wdata_o = wdata_q;
   assign bus_rnw_o   = rnw_q;
   assign done_o      = (phase == PH_DONE);
   assign rdata_o     = rdata_q;

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~bus_cs_n_o)); // R10
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_rd_n_o && !bus_wr_n_o)); // R7
   AST_STROBE_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_n_o || !bus_wr_n_o) |-> (bus_cs_n_o != {NSPACE{1'b1}})); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o)); // R10
   AST_DONE_SELECT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (bus_cs_n_o == {NSPACE{1'b1}})); // R10
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> ($stable(bus_addr_o) && $stable(bus_rnw_o))); // R9

endmodule

// File: tb/cs_bus_timer_tb.sv
module cs_bus_timer_tb_top;

   typedef struct packed {
      logic       rnw;
      logic [1:0] sp;
      logic [1:0] tac;
      logic [1:0] ws;
      logic [1:0] sel;
      logic [1:0] rh;
      logic [3:0] rden;
      logic [3:0] recov;
      logic [3:0] ea;
      logic [3:0] es;
      logic [3:0] eh;
   } vec_t;

   localparam int NVEC = 11;
   localparam vec_t TBL [NVEC] = '{
      {1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 4'h0, 4'h0, 4'd0, 4'd1, 4'd1},
      {1'b0, 2'd1, 2'd1, 2'd1, 2'd1, 2'd0, 4'h0, 4'h0, 4'd2, 4'd3, 4'd3},
      {1'b0, 2'd2, 2'd2, 2'd3, 2'd2, 2'd0, 4'h0, 4'h0, 4'd4, 4'd7, 4'd7},
      {1'b0, 2'd3, 2'd3, 2'd2, 2'd3, 2'd0, 4'h0, 4'h0, 4'd4, 4'd5, 4'd5},
      {1'b0, 2'd0, 2'd2, 2'd3, 2'd1, 2'd0, 4'h0, 4'h0, 4'd0, 4'd0, 4'd0},
      {1'b0, 2'd1, 2'd1, 2'd2, 2'd1, 2'd0, 4'h0, 4'h2, 4'd0, 4'd0, 4'd0},
      {1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 4'hF, 4'h0, 4'd0, 4'd0, 4'd0},
      {1'b1, 2'd1, 2'd1, 2'd0, 2'd0, 2'd2, 4'hF, 4'h0, 4'd2, 4'd0, 4'd4},
      {1'b1, 2'd2, 2'd2, 2'd0, 2'd0, 2'd3, 4'hF, 4'h0, 4'd4, 4'd0, 4'd6},
      {1'b1, 2'd3, 2'd2, 2'd0, 2'd0, 2'd3, 4'h7, 4'h0, 4'd0, 4'd0, 4'd0},
      {1'b1, 2'd2, 2'd2, 2'd0, 2'd0, 2'd3, 4'hF, 4'h4, 4'd0, 4'd0, 4'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        rnw_i = 1'b1;
   logic [1:0]  space_i = '0;
   logic [23:0] addr_i = '0;
   logic [15:0] wdata_i = '0;
   logic [1:0]  cfg_addr_dly_i = '0;
   logic [1:0]  cfg_wr_sh_i = '0;
   logic [1:0]  cfg_wr_sel_i = '0;
   logic [7:0]  cfg_rd_hold_i = '0;
   logic [3:0]  cfg_rd_en_i = '0;
   logic [3:0]  cfg_recov_i = '0;
   logic [15:0] bus_rdata_i = '0;
   logic [23:0] bus_addr_o;
   logic [3:0]  bus_cs_n_o;
   logic        bus_rd_n_o, bus_wr_n_o, bus_rnw_o, busy_o, done_o;
   logic [15:0] bus_wdata_o, rdata_o;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   cs_bus_timer dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rnw_i(rnw_i),
      .space_i(space_i), .addr_i(addr_i), .wdata_i(wdata_i),
      .cfg_addr_dly_i(cfg_addr_dly_i), .cfg_wr_sh_i(cfg_wr_sh_i),
      .cfg_wr_sel_i(cfg_wr_sel_i), .cfg_rd_hold_i(cfg_rd_hold_i),
      .cfg_rd_en_i(cfg_rd_en_i), .cfg_recov_i(cfg_recov_i),
      .bus_rdata_i(bus_rdata_i), .bus_addr_o(bus_addr_o),
      .bus_cs_n_o(bus_cs_n_o), .bus_rd_n_o(bus_rd_n_o),
      .bus_wr_n_o(bus_wr_n_o), .bus_rnw_o(bus_rnw_o),
      .bus_wdata_o(bus_wdata_o), .busy_o(busy_o), .done_o(done_o),
      .rdata_o(rdata_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic string tag_of(input int i);
      case (i)
         0, 1, 2, 3: return "R3";
         4:          return "R4";
         5, 10:      return "R6";
         default:    return "R5";
      endcase
   endfunction

   task automatic run_cycle(input vec_t v, input int idx, input bit intrude);
      logic [23:0] a = 24'h100000 + 24'(idx) * 24'h1111;
      logic [15:0] wd = 16'hA500 + 16'(idx);
      logic [15:0] base = 16'h3000 + 16'(idx) * 16'h0100;
      string tg = intrude ? "R9" : tag_of(idx);
      int cs_first = -1, cs_rise = -1, s_first = -1, s_cnt = 0;
      int s_last = -1, done_first = -1, done_cnt = 0;
      bit bad_cs = 0, bad_str = 0, busy_after = 0;
      int t = 0;
      @(negedge clk);
      cfg_addr_dly_i = v.tac;
      cfg_wr_sh_i    = v.ws;
      cfg_wr_sel_i   = v.sel;
      cfg_rd_hold_i  = {4{v.rh}};
      cfg_rd_en_i    = v.rden;
      cfg_recov_i    = v.recov;
      start_i = 1'b1; rnw_i = v.rnw; space_i = v.sp; addr_i = a; wdata_i = wd;
      while (1) begin
         @(negedge clk);
         t++;
         if (t == 1) begin
            chk(bus_addr_o == a, {tg, " R2 address valid"}, int'(bus_addr_o), int'(a));
            chk(bus_rnw_o == v.rnw, {tg, " R7 direction"}, int'(bus_rnw_o), int'(v.rnw));
         end
         if (bus_cs_n_o != 4'hF) begin
            if (bus_cs_n_o != ~(4'b0001 << v.sp)) bad_cs = 1;
            if (cs_first < 0) cs_first = t;
         end else if (cs_first >= 0 && cs_rise < 0) begin
            cs_rise = t;
         end
         if (v.rnw ? !bus_rd_n_o : !bus_wr_n_o) begin
            if (s_first < 0) s_first = t;
            s_cnt++;
            s_last = t;
         end
         if (v.rnw ? !bus_wr_n_o : !bus_rd_n_o) bad_str = 1;
         if (done_o) begin
            done_cnt++;
            if (done_first < 0) done_first = t;
         end
         if (cs_rise >= 0 && t == cs_rise + 1 && busy_o) busy_after = 1;
         // drive next inputs after sampling
         if (t == 1) start_i = 1'b0;
         if (intrude && t == 2) begin
            start_i = 1'b1; space_i = v.sp ^ 2'b11; addr_i = 24'hFFFFFF;
            rnw_i = ~v.rnw;
         end
         if (intrude && t == 3) start_i = 1'b0;
         bus_rdata_i = base + 16'(t);
         if (cs_rise >= 0 && t >= cs_rise + 3) break;
         if (t >= 120) begin
            chk(0, {tg, " watchdog: access never completed"}, t, 0);
            return;
         end
      end
      chk(cs_first - 1 == int'(v.ea), {tg, " R2 address delay"}, cs_first - 1, int'(v.ea));
      chk(s_first - cs_first == int'(v.es), {tg, " R3 setup"}, s_first - cs_first, int'(v.es));
      chk(cs_rise - (s_last + 1) == int'(v.eh), {tg, " R3/R5 hold"},
          cs_rise - (s_last + 1), int'(v.eh));
      chk(s_cnt == 4 && s_last - s_first == 3, {tg, " R7 strobe width"}, s_cnt, 4);
      chk(!bad_str, {tg, " R7 other strobe quiet"}, int'(bad_str), 0);
      chk(!bad_cs, {tg, " R10 select line"}, int'(bad_cs), 0);
      chk(done_first == cs_rise, {tg, " R10 done tick"}, done_first, cs_rise);
      chk(done_cnt == 1, {tg, " R10 done count"}, done_cnt, 1);
      chk(!busy_after && !busy_o, {tg, " R10 idle after done"}, int'(busy_after), 0);
      chk(bus_addr_o == a, {tg, " R9 address held"}, int'(bus_addr_o), int'(a));
      if (v.rnw)
         chk(rdata_o == base + 16'(int'(v.ea) + int'(v.es) + 4),
             {tg, " R8 read capture"}, int'(rdata_o),
             int'(base + 16'(int'(v.ea) + int'(v.es) + 4)));
      else
         chk(bus_wdata_o == wd, {tg, " R7 write data"}, int'(bus_wdata_o), int'(wd));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk(bus_cs_n_o == 4'hF && bus_rd_n_o && bus_wr_n_o, "R1 strobes in reset",
          int'({bus_cs_n_o, bus_rd_n_o, bus_wr_n_o}), 63);
      chk(!done_o && !busy_o, "R1 status in reset", int'({done_o, busy_o}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(bus_cs_n_o == 4'hF && bus_rd_n_o && bus_wr_n_o && !busy_o && !done_o,
          "R1 idle after release", int'({bus_cs_n_o, bus_rd_n_o, bus_wr_n_o}), 63);
      for (int i = 0; i < NVEC; i++) run_cycle(TBL[i], i, 1'b0);
      // R9: start pulsed mid-access to a different space must be ignored
      run_cycle(TBL[1], 1, 1'b1);
      run_cycle(TBL[8], 8, 1'b1);
      repeat (4) @(negedge clk);
      chk(!busy_o && bus_cs_n_o == 4'hF, "R9 no extra access", int'(busy_o), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule